// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the 32-bit program counter of a simple in-order fetch stage and works out, every cycle, the address the counter moves to next. It looks at the instruction word currently fetched and sorts it into one of six kinds. Ordinary instructions step forward one word. An equal or not-equal branch moves relative to the following instruction, and a taken branch uses a signed word count. A direct jump, with or without link, lands on a target built from the instruction and the upper address region. A register jump goes to a full 32-bit address supplied by the register file.

The surrounding pipeline presents the instruction, the two register values to compare and the register jump address, and raises `advance` when the counter may move. The block shows the current counter and the return address that a jump-and-link writes back. Instruction memory, the register write of the return address, delay slots and exceptions belong to other blocks.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` becomes the parameter `START_ADDR` (default 0x0040_0000) at that edge.
- R2: When `advance` is low at a rising edge (and `rst` is low), `pc` keeps its value whatever the other inputs are.
- R3: An instruction that is not a branch or jump moves `pc` to `pc + 4`. This holds for every opcode other than 0, 2, 3, 4 and 5, and for opcode 0 whenever bits [5:0] are not 8.
- R4: Opcode 4 (bits [31:26]) is branch-if-equal. If `op_a == op_b`, `pc` becomes `pc + 4 + (sign-extended bits [15:0]) * 4`. Otherwise it becomes `pc + 4`.
- R5: Opcode 5 is branch-if-not-equal. It uses the same target as R4, but the branch is taken only when `op_a != op_b`.
- R6: The branch offset is signed. An offset of 0xFFFF returns to the branch itself, and an offset of 3 lands 16 bytes past the branch.
- R7: Opcode 2 is a jump. `pc` becomes {(pc + 4)[31:28], bits [25:0], 2'b00}, so the upper four bits come from the next sequential address.
- R8: Opcode 3 is jump-and-link. It uses the target of R7. At all times `link_addr` equals `pc + 4`, which is the return address to write back.
- R9: Opcode 0 with bits [5:0] equal to 8 is a register jump. `pc` becomes `reg_target` exactly, all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| advance | input | 1 | Allows the counter to move this cycle |
| instr | input | 32 | Instruction word at the current counter |
| op_a | input | 32 | First register value for branch comparison |
| op_b | input | 32 | Second register value for branch comparison |
| reg_target | input | 32 | Register value used as the register jump address |
| pc | output | 32 | Current program counter |
| link_addr | output | 32 | Return address (pc + 4) for jump-and-link |

## Verification
Any error in the decode, the target arithmetic or the selection shows up on `pc` one clock after the instruction is presented with `advance` high, because the counter is the only state in the block. A wrong kind or a wrong offset lands on an address that differs from the bench model at that edge. The error then spreads to every later address, since each step starts from the corrupted counter. Upper-nibble mistakes in direct jumps show only when the counter sits outside region zero, so the bench first uses a register jump to move the counter into a high region.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN     = 32;
    localparam int OP_W     = 6;
    localparam int FN_W     = 6;
    localparam int IMM_W    = 16;
    localparam int JIDX_W   = 26;
    localparam int ALIGN_W  = 2;
    localparam int REGION_W = XLEN - JIDX_W - ALIGN_W;

    localparam logic [OP_W-1:0] OPC_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0] OPC_JUMP    = 6'd2;
    localparam logic [OP_W-1:0] OPC_JLINK   = 6'd3;
    localparam logic [OP_W-1:0] OPC_BREQ    = 6'd4;
    localparam logic [OP_W-1:0] OPC_BRNE    = 6'd5;
    localparam logic [FN_W-1:0] FN_REGJUMP  = 6'd8;

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    typedef enum logic [2:0] {
        K_SEQ,
        K_BEQ,
        K_BNE,
        K_JMP,
        K_JAL,
        K_JR
    } flow_kind_e;

    typedef struct packed {
        flow_kind_e          kind;
        logic [XLEN-1:0]     br_offset;
        logic [JIDX_W-1:0]   jidx;
    } flow_dec_t;

    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] branch;
        logic [XLEN-1:0] jump;
        logic [XLEN-1:0] regjmp;
    } flow_cand_t;

    function automatic logic [XLEN-1:0] word_offset(input logic [IMM_W-1:0] imm);
        logic [XLEN-1:0] ext;
        ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        return ext << ALIGN_W;
    endfunction

    function automatic logic [XLEN-1:0] region_target(input logic [XLEN-1:0] next_seq,
                                                      input logic [JIDX_W-1:0] idx);
        return {next_seq[XLEN-1 -: REGION_W], idx, {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output flow_dec_t       dec
);
    logic [OP_W-1:0]  opc;
    logic [FN_W-1:0]  fn;
    logic [IMM_W-1:0] imm;

    assign opc = instr[XLEN-1 -: OP_W];
    assign fn  = instr[FN_W-1:0];
    assign imm = instr[IMM_W-1:0];

    always_comb begin
        dec.br_offset = word_offset(imm);
        dec.jidx      = instr[JIDX_W-1:0];
        unique case (opc)
            OPC_BREQ:    dec.kind = K_BEQ;
            OPC_BRNE:    dec.kind = K_BNE;
            OPC_JUMP:    dec.kind = K_JMP;
            OPC_JLINK:   dec.kind = K_JAL;
            OPC_SPECIAL: dec.kind = (fn == FN_REGJUMP) ? K_JR : K_SEQ;
            default:     dec.kind = K_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  flow_dec_t       dec,
    input  logic [XLEN-1:0] reg_target,
    output flow_cand_t      cand
);
    logic [XLEN-1:0] next_seq;

    assign next_seq = pc + STEP;

    always_comb begin
        cand.seq    = next_seq;
        cand.branch = next_seq + dec.br_offset;
        cand.jump   = region_target(next_seq, dec.jidx);
        cand.regjmp = reg_target;
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  flow_kind_e      kind,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  flow_cand_t      cand,
    output logic [XLEN-1:0] next_pc
);
    logic same;

    assign same = (op_a == op_b);

    always_comb begin
        unique case (kind)
            K_BEQ:         next_pc = same  ? cand.branch : cand.seq;
            K_BNE:         next_pc = !same ? cand.branch : cand.seq;
            K_JMP, K_JAL:  next_pc = cand.jump;
            K_JR:          next_pc = cand.regjmp;
            default:       next_pc = cand.seq;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] START_ADDR = 32'h0040_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        advance,
    input  logic [31:0] instr,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic [31:0] reg_target,
    output logic [31:0] pc,
    output logic [31:0] link_addr
);
    flow_dec_t       dec;
    flow_cand_t      cand;
    logic [XLEN-1:0] next_pc;
    logic [XLEN-1:0] pc_q;

    npc_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    npc_targets u_targets (
        .pc         (pc_q),
        .dec        (dec),
        .reg_target (reg_target),
        .cand       (cand)
    );

    npc_select u_select (
        .kind    (dec.kind),
        .op_a    (op_a),
        .op_b    (op_b),
        .cand    (cand),
        .next_pc (next_pc)
    );

    always_ff @(posedge clk) begin
        if (rst)          pc_q <= START_ADDR;
        else if (advance) pc_q <= next_pc;
    end

    assign pc        = pc_q;
    assign link_addr = cand.seq;

    // R1
    reset_load_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pc == START_ADDR);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(pc));

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && dec.kind == K_SEQ) |=> pc == $past(pc) + 32'd4);

    // R4
    beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && dec.kind == K_BEQ && op_a != op_b) |=> pc == $past(pc) + 32'd4);

    // R5
    bne_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && dec.kind == K_BNE && op_a == op_b) |=> pc == $past(pc) + 32'd4);

    // R7
    jump_region_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && (dec.kind == K_JMP || dec.kind == K_JAL))
        |=> (pc[1:0] == 2'b00 && pc[31:28] == $past(link_addr[31:28])));

    // R9
    regjump_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && dec.kind == K_JR) |=> pc == $past(reg_target));
endmodule

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;
    localparam logic [31:0] START = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst, advance;
    logic [31:0] instr, op_a, op_b, reg_target;
    logic [31:0] pc, link_addr;

    int total = 0;
    int bad   = 0;
    logic [31:0] model_pc;

    npc_unit #(.START_ADDR(START)) i_npc_unit (
        .clk(clk), .rst(rst), .advance(advance), .instr(instr),
        .op_a(op_a), .op_b(op_b), .reg_target(reg_target),
        .pc(pc), .link_addr(link_addr)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] expect_next(input logic [31:0] cur, input logic [31:0] ins,
                                                input logic [31:0] a, input logic [31:0] b,
                                                input logic [31:0] r);
        logic [31:0] nxt;
        logic [31:0] off;
        nxt = cur + 32'd4;
        off = {{14{ins[15]}}, ins[15:0], 2'b00};
        case (ins[31:26])
            6'd4: return (a == b) ? nxt + off : nxt;
            6'd5: return (a != b) ? nxt + off : nxt;
            6'd2, 6'd3: return {nxt[31:28], ins[25:0], 2'b00};
            6'd0: return (ins[5:0] == 6'd8) ? r : nxt;
            default: return nxt;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(input string req, input logic adv, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] r);
        advance = adv; instr = ins; op_a = a; op_b = b; reg_target = r;
        #1;
        check("R8 link", link_addr, model_pc + 32'd4);
        if (adv) model_pc = expect_next(model_pc, ins, a, b, r);
        @(negedge clk);
        check(req, pc, model_pc);
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; advance = 1'b0; instr = '0; op_a = '0; op_b = '0; reg_target = '0;
        @(negedge clk); @(negedge clk);
        check("R1 reset", pc, START);
        model_pc = START;
        rst = 1'b0;

        // R3: plain instruction and opcode 0 with another funct
        step("R3 seq", 1'b1, 32'h012A_4020, 1, 2, 0);
        step("R3 special non-jr", 1'b1, 32'h0000_0009, 0, 0, 32'h1234_5670);
        // R2: hold with a jump presented
        step("R2 hold", 1'b0, {6'd2, 26'h3FF_FFFF}, 0, 0, 32'hDEAD_BEE0);
        // R4 / R6: beq offset 3 skips 16 bytes past the branch
        step("R4 R6 beq +3", 1'b1, {6'd4, 5'd9, 5'd0, 16'd3}, 7, 7, 0);
        step("R4 beq not taken", 1'b1, {6'd4, 5'd9, 5'd0, 16'd3}, 7, 8, 0);
        // R6: offset -1 returns to itself
        step("R6 beq -1", 1'b1, {6'd4, 10'd0, 16'hFFFF}, 5, 5, 0);
        // R5
        step("R5 bne taken", 1'b1, {6'd5, 10'd0, 16'hFFF0}, 1, 2, 0);
        step("R5 bne not taken", 1'b1, {6'd5, 10'd0, 16'h0100}, 3, 3, 0);
        // R9: move into a high region
        step("R9 jr", 1'b1, 32'h0120_0008, 0, 0, 32'hA000_1000);
        // R7: upper nibble kept from pc+4
        step("R7 jump region", 1'b1, {6'd2, 26'h000_0040}, 0, 0, 0);
        // R8: jal target
        step("R8 jal", 1'b1, {6'd3, 26'h123_4567}, 0, 0, 0);
        // R7: pc+4 crosses into the next region
        step("R9 jr edge", 1'b1, 32'h0000_0008, 0, 0, 32'h2FFF_FFFC);
        step("R7 jump carry", 1'b1, {6'd2, 26'h000_0010}, 0, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ins, a, b, r;
            logic adv;
            int cls;
            cls = int'($urandom_range(0, 7));
            ins = $urandom;
            case (cls)
                0: ins[31:26] = 6'd4;
                1: ins[31:26] = 6'd5;
                2: ins[31:26] = 6'd2;
                3: ins[31:26] = 6'd3;
                4: begin ins[31:26] = 6'd0; ins[5:0] = 6'd8; end
                5: ins[31:26] = 6'd0;
                default: if (ins[31:26] <= 6'd5) ins[31:26] = 6'd8;
            endcase
            a = $urandom;
            b = ($urandom_range(0, 1) == 1) ? a : $urandom;
            r = {$urandom, 2'b00} >> 0;
            r[1:0] = 2'b00;
            adv = ($urandom_range(0, 5) != 0);
            step("R3 R4 R5 R7 R9 random", adv, ins, a, b, r);
        end

        // R1: reset in the middle of a run
        rst = 1'b1; advance = 1'b1;
        @(negedge clk);
        check("R1 mid reset", pc, START);
        rst = 1'b0; model_pc = START;
        step("R3 after reset", 1'b1, 32'h8C00_0000, 0, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule